// File: doc/BRIEF.md
# Asynchronous SRAM Bus Timing Monitor

This block watches the control, address and data lines of an asynchronous static RAM bus and samples them on a fast reference clock. It measures every interval in reference-clock ticks and raises a sticky error flag for each timing rule a bus master breaks. The rules cover the width of the write window, how long the chip has been selected, address and data stability before a write ends, minimum read and write cycle lengths, and bus contention between the memory and an external data driver. It also counts completed writes. It is meant to sit beside a memory controller, in simulation or on silicon, and report protocol errors without modelling the memory contents.

A write exists only while chip select and write enable are both low. It begins at the later of the two falling strobes and ends at the earlier of the two rising strobes. All rule checks against the end of a write use the last sample in which the write was still active. Inputs pass through a parameterised synchroniser before they are measured, so the flags appear a fixed number of cycles after the bus activity that causes them. Every threshold is a minimum count of reference ticks, and every counter saturates.

Top module: `sram_bus_monitor`

## Requirements
- R1: A write is active in a sample when both `cs_n` and `we_n` are 0. A write ends in the first sample where it is no longer active, whichever strobe rose. Each end of a write adds exactly 1 to `wr_count`.
- R2: If a write was active in fewer than `WP_MIN` consecutive samples, flag bit 0 (window width) sets.
- R3: If `cs_n` was 0 in fewer than `CW_MIN` consecutive samples up to the last active write sample, flag bit 1 (select to end) sets.
- R4: If `addr` was unchanged over fewer than `AW_MIN` samples up to the last active write sample, flag bit 2 (address to end) sets. An address change in the sample where the write ends is legal.
- R5: If `data` was unchanged over fewer than `DW_MIN` samples up to the last active write sample, flag bit 3 (data setup) sets. A data change in the sample where the write ends is legal.
- R6: An address period is a run of samples with the same `addr`. If a write ends inside a period that is shorter than `WC_MIN` samples, flag bit 4 (write cycle) sets when the address changes.
- R7: A read sample has `cs_n`=0, `we_n`=1 and `oe_n`=0. If a period holds a read sample, no write and fewer than `RC_MIN` samples, flag bit 5 (read cycle) sets when the address changes. Chip select low with `oe_n`=1 does not count as a read.
- R8: A sample with `drv_en`=1, `cs_n`=0, `we_n`=1 and `oe_n`=0 sets flag bit 6 (contention). Driving while `we_n`=0 never sets it.
- R9: A flag stays set until `clr` is 1 in a clock cycle, which clears all flags. `clr` does not change `wr_count`.
- R10: After reset all flags and `wr_count` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Clears all error flags |
| cs_n | input | 1 | Bus chip select, active low |
| we_n | input | 1 | Bus write enable, active low |
| oe_n | input | 1 | Bus output enable, active low |
| drv_en | input | 1 | External data driver enabled |
| addr | input | ADDR_W | Bus address |
| data | input | DATA_W | Bus data seen by the monitor |
| err | output | 7 | Sticky flags, bits 0..6 as in R2..R8 |
| wr_count | output | CNT_W | Completed writes, wraps |

## Verification
The bench sweeps strobe order, window length, data arrival, address hold and which strobe rises first. In each case it predicts every flag from the tick arithmetic. A design that ends the window at the later rising strobe would miss short windows when the strobes release one tick apart. A design that counts the end sample itself would pass windows one tick too short. A design that treats an address or data change in the end sample as a setup error would flag legal zero-hold writes. Read-cycle sweeps include chip select without output enable. Contention is swept over all sixteen strobe and driver combinations, so a monitor that flags driving during a write, or that ignores output enable, is caught.

// File: rtl/sram_mon_pkg.sv
package sram_mon_pkg;
   localparam int NRULES = 7;

   typedef enum logic [2:0] {
      RULE_WP   = 3'd0,
      RULE_CW   = 3'd1,
      RULE_AW   = 3'd2,
      RULE_DW   = 3'd3,
      RULE_WC   = 3'd4,
      RULE_RC   = 3'd5,
      RULE_CONT = 3'd6
   } rule_e;

   typedef struct packed {
      logic cs_n;
      logic we_n;
      logic oe_n;
      logic drv;
   } ctl_t;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // counter width that can hold every threshold plus a saturation headroom
   function automatic int tick_width(input int max_th);
      return $clog2(max_th + 2);
   endfunction
endpackage

// File: rtl/sram_mon_sampler.sv
module sram_mon_sampler #(
   parameter int W = 8,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] raw,
   output logic [W-1:0] cur
);
   logic [W-1:0] pre;

   generate
      if (STAGES == 0) begin : g_direct
         assign pre = raw;
      end else begin : g_sync
         logic [W-1:0] chain [STAGES];
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
               if (!rst_n) chain[i] <= RST_VAL;
               else if (i == 0) chain[i] <= raw;
               else chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
         end
         assign pre = chain[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) cur <= RST_VAL;
      else        cur <= pre;
   end
endmodule

// File: rtl/sram_mon_runlen.sv
module sram_mon_runlen #(
   parameter int CW = 3,
   parameter int RESTART = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   output logic [CW-1:0] cnt
);
   localparam logic [CW-1:0] SAT = '1;
   localparam logic [CW-1:0] RST_CNT = CW'(RESTART);

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (!inc)       cnt <= RST_CNT;
      else if (cnt != SAT) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/sram_mon_flags.sv
module sram_mon_flags #(
   parameter int N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [N-1:0] set,
   output logic [N-1:0] flags
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_flag
         always_ff @(posedge clk) begin
            if (!rst_n)      flags[i] <= 1'b0;
            else if (set[i]) flags[i] <= 1'b1;
            else if (clr)    flags[i] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/sram_bus_monitor.sv
module sram_bus_monitor
   import sram_mon_pkg::*;
#(
   parameter int ADDR_W = 19,
   parameter int DATA_W = 8,
   parameter int SYNC_STAGES = 2,
   parameter int WP_MIN = 4,
   parameter int CW_MIN = 5,
   parameter int AW_MIN = 5,
   parameter int DW_MIN = 3,
   parameter int WC_MIN = 6,
   parameter int RC_MIN = 6,
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              cs_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic              drv_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic [NRULES-1:0] err,
   output logic [CNT_W-1:0]  wr_count
);
   localparam int MAX_TH = max2(max2(max2(WP_MIN, CW_MIN), max2(AW_MIN, DW_MIN)),
                                max2(WC_MIN, RC_MIN));
   localparam int TW = tick_width(MAX_TH);
   localparam int SW = $bits(ctl_t) + ADDR_W + DATA_W;
   localparam ctl_t CTL_IDLE = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
   localparam logic [SW-1:0] SMP_RST = {CTL_IDLE, {(ADDR_W + DATA_W){1'b0}}};

   generate
      if (WP_MIN < 1 || CW_MIN < 1 || AW_MIN < 1 || DW_MIN < 1 ||
          WC_MIN < 1 || RC_MIN < 1) begin : g_bad_thresh
         $error("sram_bus_monitor: every threshold must be at least one tick");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("sram_bus_monitor: SYNC_STAGES must be 0..3");
      end
      if (ADDR_W < 1 || DATA_W < 1 || CNT_W < 1) begin : g_bad_width
         $error("sram_bus_monitor: widths must be positive");
      end
   endgenerate

   // ---- sampled bus -------------------------------------------------------
   ctl_t              c_ctl;
   logic [ADDR_W-1:0] c_addr;
   logic [DATA_W-1:0] c_data;
   logic [SW-1:0]     smp;

   sram_mon_sampler #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SMP_RST)) u_smp (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   ({cs_n, we_n, oe_n, drv_en, addr, data}),
      .cur   (smp)
   );

   assign c_ctl  = ctl_t'(smp[SW-1 -: $bits(ctl_t)]);
   assign c_addr = smp[DATA_W +: ADDR_W];
   assign c_data = smp[DATA_W-1:0];

   logic c_cs_n, c_we_n, c_oe_n, c_drv;
   assign c_cs_n = c_ctl.cs_n;
   assign c_we_n = c_ctl.we_n;
   assign c_oe_n = c_ctl.oe_n;
   assign c_drv  = c_ctl.drv;

   // ---- previous sample and events ---------------------------------------
   logic [ADDR_W-1:0] p_addr;
   logic [DATA_W-1:0] p_data;
   logic              p_wr;
   logic c_wr, c_rd, wr_end, a_chg;

   assign c_wr   = !c_cs_n && !c_we_n;
   assign c_rd   = !c_cs_n &&  c_we_n && !c_oe_n;
   assign wr_end = p_wr && !c_wr;
   assign a_chg  = (c_addr != p_addr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p_addr <= '0;
         p_data <= '0;
         p_wr   <= 1'b0;
      end else begin
         p_addr <= c_addr;
         p_data <= c_data;
         p_wr   <= c_wr;
      end
   end

   // ---- run-length counters ----------------------------------------------
   logic [TW-1:0] wp_cnt, cw_cnt, ad_cnt, dt_cnt;

   sram_mon_runlen #(.CW(TW), .RESTART(0)) u_wp (
      .clk(clk), .rst_n(rst_n), .inc(c_wr), .cnt(wp_cnt));
   sram_mon_runlen #(.CW(TW), .RESTART(0)) u_cw (
      .clk(clk), .rst_n(rst_n), .inc(!c_cs_n), .cnt(cw_cnt));
   sram_mon_runlen #(.CW(TW), .RESTART(1)) u_ad (
      .clk(clk), .rst_n(rst_n), .inc(!a_chg), .cnt(ad_cnt));
   sram_mon_runlen #(.CW(TW), .RESTART(1)) u_dt (
      .clk(clk), .rst_n(rst_n), .inc(c_data == p_data), .cnt(dt_cnt));

   // ---- address period bookkeeping ---------------------------------------
   logic had_wr, had_rd, per_wr;
   assign per_wr = had_wr || wr_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         had_wr <= 1'b0;
         had_rd <= 1'b0;
      end else if (a_chg) begin
         had_wr <= 1'b0;
         had_rd <= c_rd;
      end else begin
         had_wr <= per_wr;
         had_rd <= had_rd || c_rd;
      end
   end

   // ---- rule evaluation --------------------------------------------------
   logic [NRULES-1:0] set;

   always_comb begin
      set = '0;
      set[RULE_WP]   = wr_end && (wp_cnt < TW'(WP_MIN));
      set[RULE_CW]   = wr_end && (cw_cnt < TW'(CW_MIN));
      set[RULE_AW]   = wr_end && (ad_cnt < TW'(AW_MIN));
      set[RULE_DW]   = wr_end && (dt_cnt < TW'(DW_MIN));
      set[RULE_WC]   = a_chg && per_wr && (ad_cnt < TW'(WC_MIN));
      set[RULE_RC]   = a_chg && !per_wr && had_rd && (ad_cnt < TW'(RC_MIN));
      set[RULE_CONT] = c_rd && c_drv;
   end

   sram_mon_flags #(.N(NRULES)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .set   (set),
      .flags (err)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      wr_count <= '0;
      else if (wr_end) wr_count <= wr_count + 1'b1;
   end
endmodule

// File: rtl/sram_bus_monitor_chk.sv
module sram_bus_monitor_chk #(
   parameter int N = 7,
   parameter int CNT_W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         clr,
   input logic [N-1:0] err,
   input logic [CNT_W-1:0] wr_count,
   input logic         c_cs_n,
   input logic         c_we_n,
   input logic         c_oe_n,
   input logic         c_drv,
   input logic         wr_end
);
   // R1
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_end |=> (wr_count == CNT_W'($past(wr_count) + 1'b1)));

   // R1
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_end |=> $stable(wr_count));

   // R8
   contention_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!c_cs_n && c_we_n && !c_oe_n && c_drv) |=> err[N-1]);

   // R8
   no_contention_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!err[N-1] && !clr && !(!c_cs_n && c_we_n && !c_oe_n && c_drv)) |=> !err[N-1]);

   // R9
   flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (($past(err) & ~err) == '0));
endmodule

bind sram_bus_monitor sram_bus_monitor_chk #(.N(sram_mon_pkg::NRULES), .CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clr      (clr),
   .err      (err),
   .wr_count (wr_count),
   .c_cs_n   (c_cs_n),
   .c_we_n   (c_we_n),
   .c_oe_n   (c_oe_n),
   .c_drv    (c_drv),
   .wr_end   (wr_end)
);

// File: tb/sram_bus_monitor_test.sv
module sram_bus_monitor_test;
   localparam int ADDR_W = 19;
   localparam int DATA_W = 8;
   localparam int CNT_W = 16;
   localparam int WP_MIN = 4, CW_MIN = 5, AW_MIN = 5, DW_MIN = 3, WC_MIN = 6, RC_MIN = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr = 1'b0;
   logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, drv_en = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [DATA_W-1:0] data = '0;
   logic [6:0] err;
   logic [CNT_W-1:0] wr_count;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic [ADDR_W-1:0] nxt = '0;
   logic [CNT_W-1:0] exp_count = '0;

   always #5 clk = ~clk;

   sram_bus_monitor #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(2),
      .WP_MIN(WP_MIN), .CW_MIN(CW_MIN), .AW_MIN(AW_MIN), .DW_MIN(DW_MIN),
      .WC_MIN(WC_MIN), .RC_MIN(RC_MIN), .CNT_W(CNT_W)
   ) uut (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n), .drv_en(drv_en),
      .addr(addr), .data(data), .err(err), .wr_count(wr_count)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; drv_en = 1'b0;
      end
   endtask

   // fresh address, quiet bus, then clear the flags
   task automatic settle(input logic [DATA_W-1:0] dv);
      @(negedge clk);
      nxt = nxt + 1'b1;
      addr = nxt; data = dv;
      cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; drv_en = 1'b0;
      idle(8);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      idle(6);
   endtask

   task automatic run_write(input int tcs, input int twe, input int tend,
                            input int tdat, input int hold, input int who);
      logic [DATA_W-1:0] d;
      logic [ADDR_W-1:0] a0, a1;
      int win, total;
      logic [6:0] e;
      d = DATA_W'(tend * 37 + tdat * 5 + hold + who * 11 + 1);
      settle(~d);
      a0 = nxt + 1'b1;
      a1 = nxt + 2'd2;
      nxt = a1;
      total = tend + hold + 3;
      for (int i = 0; i < total; i++) begin
         @(negedge clk);
         addr = (i < tend + hold) ? a0 : a1;
         data = (i >= tdat) ? d : ~d;
         cs_n = !(i >= tcs && i < tend + ((who == 1) ? 1 : 0));
         we_n = !(i >= twe && i < tend + ((who == 2) ? 1 : 0));
         oe_n = 1'b1;
         drv_en = 1'b0;
      end
      idle(8);
      win = tend - ((tcs > twe) ? tcs : twe);
      e = '0;
      e[0] = (win < WP_MIN);
      e[1] = ((tend - tcs) < CW_MIN);
      e[2] = (tend < AW_MIN);
      e[3] = ((tend - tdat) < DW_MIN);
      e[4] = ((tend + hold) < WC_MIN);
      check("R2 window width", 32'(err[0]), 32'(e[0]));
      check("R3 select to end", 32'(err[1]), 32'(e[1]));
      check("R4 address to end", 32'(err[2]), 32'(e[2]));
      check("R5 data setup", 32'(err[3]), 32'(e[3]));
      check("R6 write cycle", 32'(err[4]), 32'(e[4]));
      check("R7 no read flag on write", 32'(err[5]), 32'd0);
      check("R8 no contention on write", 32'(err[6]), 32'd0);
      exp_count = exp_count + 1'b1;
      check("R1 write count", 32'(wr_count), 32'(exp_count));
   endtask

   task automatic run_read(input int len, input logic oe_val);
      logic [ADDR_W-1:0] a0, a1;
      settle('0);
      a0 = nxt + 1'b1;
      a1 = nxt + 2'd2;
      nxt = a1;
      for (int i = 0; i <= len; i++) begin
         @(negedge clk);
         addr = (i < len) ? a0 : a1;
         cs_n = (i >= len);
         oe_n = (i < len) ? oe_val : 1'b1;
         we_n = 1'b1;
         drv_en = 1'b0;
      end
      idle(8);
      check("R7 read cycle", 32'(err[5]), 32'((!oe_val) && (len < RC_MIN)));
      check("R7 other flags quiet on read", 32'(err[4:0]), 32'd0);
      check("R1 no count on read", 32'(wr_count), 32'(exp_count));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      idle(2);
      // R10: reset state
      check("R10 flags after reset", 32'(err), 32'd0);
      check("R10 count after reset", 32'(wr_count), 32'd0);

      // R2..R6 and R1: sweep of write shapes
      for (int tcs = 0; tcs < 3; tcs++)
         for (int twe = 0; twe < 3; twe++)
            for (int len = 1; len <= 6; len++)
               for (int dsel = 0; dsel < 3; dsel++)
                  for (int hold = 0; hold < 4; hold++)
                     for (int who = 0; who < 3; who++) begin
                        int mx, tend, tdat;
                        mx = (tcs > twe) ? tcs : twe;
                        tend = mx + len;
                        tdat = (dsel == 0) ? 0 : tend - 4 + dsel;
                        if (tdat < 0) tdat = 0;
                        run_write(tcs, twe, tend, tdat, hold, who);
                     end

      // R7: read cycle lengths, with and without output enable
      for (int len = 1; len <= 9; len++) begin
         run_read(len, 1'b0);
         run_read(len, 1'b1);
      end

      // R8: all strobe and driver combinations
      for (int c = 0; c < 16; c++) begin
         logic xc, xw, xo, xd;
         {xc, xw, xo, xd} = 4'(c);
         settle('0);
         repeat (3) begin
            @(negedge clk);
            cs_n = xc; we_n = xw; oe_n = xo; drv_en = xd;
         end
         idle(8);
         if (!xc && !xw) exp_count = exp_count + 1'b1;
         check("R8 contention", 32'(err[6]), 32'((!xc) && xw && (!xo) && xd));
         check("R1 count after combination", 32'(wr_count), 32'(exp_count));
      end

      // R9: stickiness and clear
      settle('0);
      @(negedge clk);
      cs_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; drv_en = 1'b1;
      idle(30);
      check("R9 flag held after cause ends", 32'(err[6]), 32'd1);
      @(negedge clk);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      idle(2);
      check("R9 clear empties flags", 32'(err), 32'd0);
      check("R9 clear keeps count", 32'(wr_count), 32'(exp_count));

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule